// File: doc/BRIEF.md
# Roving Input Port Selector

This block connects six input video lanes to two internal processing pipes and two output lanes. A primary 6:1 selector puts the chosen active port on the main pipe. A secondary 6:1 selector feeds the subpipe. In the two roving modes the secondary selector scans the ports that are not active, one after another, so that background processing can visit every idle input. In matrix mode the secondary selector takes a fixed port number from configuration instead.

Each output lane has its own 4:1 selector. It picks the main pipe, the subpipe, a parallel video input or a pattern source. While a roving mode is on, the subpipe carries scan traffic that is meant for background work only. A request for it is therefore replaced by the main pipe, and a per-output status bit reports the substitution. Configuration arrives as plain register-style inputs that may change on any cycle.

Top module: `rove_port_router`

## Requirements
- R1: While reset is asserted, main_port reads 0, sub_port reads 1, every pipe and output lane reads valid 0 and data 0, and rove_step and sel_err read 0.
- R2: cfg_mode codes are 0 = roving A, 1 = roving B, 2 = matrix, and 3 = matrix as well. In matrix modes, a legal cfg_active or cfg_sub value appears on main_port or sub_port one cycle later. No rove_step pulse is issued in matrix modes.
- R3: A pipe lane carries the {valid, data} of the input port its selector named on the previous cycle, so a lane lags its port register by one cycle.
- R4: A port number of 6 or 7 in cfg_active, or in cfg_sub while in a matrix mode, leaves that selector unchanged and sets sel_err. Only reset clears sel_err.
- R5: Output source codes are 0 = main pipe, 1 = subpipe, 2 = parallel input, 3 = pattern input. Each output lane registers its own choice one cycle after the pipe or input it picks, independently of the other output lane.
- R6: In roving modes, the subpipe port advances every cfg_dwell cycles, and rove_step is high for exactly the one cycle in which the new port first shows.
- R7: A roving step moves to the next higher port number, wraps from 5 to 0, and skips the active port. From the cycle after a roving mode is applied, sub_port never equals main_port.
- R8: After the active port changes in a roving mode, the next dwell step lands on the port just above the new active port (modulo 6).
- R9: If the active port becomes equal to the current subpipe port, the subpipe moves on the same edge to the port above it, rove_step pulses, and the dwell count restarts.
- R10: In roving modes, source code 1 on an output routes the main pipe instead, and bit i of out_subst is 1 for that output i. The bit is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mode code (see R2) |
| cfg_active | input | 3 | Active port number for the main pipe |
| cfg_sub | input | 3 | Subpipe port number used in matrix modes |
| cfg_dwell | input | DWELL_W | Cycles between roving steps |
| cfg_out0_src | input | 2 | Source code for output lane 0 |
| cfg_out1_src | input | 2 | Source code for output lane 1 |
| in_data | input | 6*W | Six input lanes, port p in bits [p*W +: W] |
| in_valid | input | 6 | Valid flag per input lane |
| par_data | input | W | Parallel video input data |
| par_valid | input | 1 | Parallel video input valid |
| pat_data | input | W | Pattern source data |
| pat_valid | input | 1 | Pattern source valid |
| main_data | output | W | Main pipe data |
| main_valid | output | 1 | Main pipe valid |
| sub_data | output | W | Subpipe data |
| sub_valid | output | 1 | Subpipe valid |
| out0_data | output | W | Output lane 0 data |
| out0_valid | output | 1 | Output lane 0 valid |
| out1_data | output | W | Output lane 1 data |
| out1_valid | output | 1 | Output lane 1 valid |
| main_port | output | 3 | Port currently routed to the main pipe |
| sub_port | output | 3 | Port currently routed to the subpipe |
| rove_step | output | 1 | One-cycle pulse on each roving port change |
| sel_err | output | 1 | Sticky illegal port number flag |
| out_subst | output | 2 | Per-output subpipe substitution status |

## Verification
The bench goes after the scan sequence at its edges. It checks the wrap from port 5 to 0 and the skip over the active port; a design without the skip would expose the active port on the subpipe. It also checks the restart after an active change, where a design that kept scanning from its old position would land on 4 rather than 1. Another check makes the active port equal to the port being scanned, where a design without the immediate jump would show sub_port equal to main_port for a whole dwell. Illegal port numbers, substitution in both roving modes, and mode 3 acting as matrix are each checked too; a design that got these wrong would change port, lose the error flag, or leak subpipe traffic onto an output.

// File: rtl/rove_pkg.sv
package rove_pkg;
    typedef enum logic [1:0] {
        MODE_ROVE_A = 2'd0,
        MODE_ROVE_B = 2'd1,
        MODE_MATRIX = 2'd2,
        MODE_MATRIX_ALT = 2'd3
    } rove_mode_e;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_SUB  = 2'd1,
        SRC_PAR  = 2'd2,
        SRC_PAT  = 2'd3
    } out_src_e;

    function automatic logic is_roving(input logic [1:0] mode);
        return (mode == MODE_ROVE_A) || (mode == MODE_ROVE_B);
    endfunction
endpackage

// File: rtl/rove_scan.sv
module rove_scan #(
    parameter int NPORT   = 6,
    parameter int DWELL_W = 8,
    localparam int PW     = $clog2(NPORT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               roving,
    input  logic [PW-1:0]      cfg_active,
    input  logic [PW-1:0]      cfg_sub,
    input  logic [DWELL_W-1:0] cfg_dwell,
    output logic [PW-1:0]      main_port,
    output logic [PW-1:0]      sub_port,
    output logic               step,
    output logic               err
);
    typedef struct packed {
        logic [PW-1:0]      main;
        logic [PW-1:0]      sub;
        logic [DWELL_W-1:0] cnt;
        logic               pend;
        logic               step;
        logic               err;
    } scan_t;

    scan_t s_d, s_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (int'(p) == NPORT - 1) ? '0 : PW'(p + 1'b1);
    endfunction

    logic [DWELL_W-1:0] limit_m1;
    logic               boundary;
    logic               act_moved;
    logic [PW-1:0]      cand;

    always_comb begin
        s_d       = s_q;
        s_d.step  = 1'b0;
        cand      = s_q.sub;
        if (int'(cfg_active) < NPORT) s_d.main = cfg_active;
        else                          s_d.err  = 1'b1;
        act_moved = (s_d.main != s_q.main);
        // a dwell of zero behaves as a dwell of one
        limit_m1  = (cfg_dwell == '0) ? '0 : cfg_dwell - 1'b1;
        boundary  = (s_q.cnt >= limit_m1);

        if (roving) begin
            if (act_moved) s_d.pend = 1'b1;
            if (boundary) begin
                cand = (s_q.pend || act_moved) ? wrap_inc(s_d.main) : wrap_inc(s_q.sub);
                if (cand == s_d.main) cand = wrap_inc(cand);
                s_d.sub  = cand;
                s_d.cnt  = '0;
                s_d.pend = 1'b0;
                s_d.step = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.sub == s_d.main) begin
                    s_d.sub  = wrap_inc(s_d.main);
                    s_d.cnt  = '0;
                    s_d.pend = 1'b0;
                    s_d.step = 1'b1;
                end
            end
        end else begin
            s_d.cnt  = '0;
            s_d.pend = 1'b0;
            if (int'(cfg_sub) < NPORT) s_d.sub = cfg_sub;
            else                       s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sub  <= PW'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign main_port = s_q.main;
    assign sub_port  = s_q.sub;
    assign step      = s_q.step;
    assign err       = s_q.err;
endmodule

// File: rtl/rove_pipe_mux.sv
module rove_pipe_mux #(
    parameter int NPORT = 6,
    parameter int W     = 8,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PW-1:0]      port,
    input  logic [NPORT*W-1:0] lane_data,
    input  logic [NPORT-1:0]   lane_valid,
    output logic [W-1:0]       data,
    output logic               valid
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } beat_t;

    beat_t b_d, b_q;

    always_comb begin
        b_d = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (int'(port) == i) begin
                b_d.valid = lane_valid[i];
                b_d.data  = lane_data[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign data  = b_q.data;
    assign valid = b_q.valid;
endmodule

// File: rtl/rove_out_mux.sv
module rove_out_mux #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         roving,
    input  logic [1:0]   src,
    input  logic [W-1:0] main_data,
    input  logic         main_valid,
    input  logic [W-1:0] sub_data,
    input  logic         sub_valid,
    input  logic [W-1:0] par_data,
    input  logic         par_valid,
    input  logic [W-1:0] pat_data,
    input  logic         pat_valid,
    output logic [W-1:0] data,
    output logic         valid,
    output logic         subst
);
    import rove_pkg::*;

    typedef struct packed {
        logic         subst;
        logic         valid;
        logic [W-1:0] data;
    } olane_t;

    olane_t o_d, o_q;

    always_comb begin
        o_d = '0;
        case (out_src_e'(src))
            SRC_MAIN: begin o_d.valid = main_valid; o_d.data = main_data; end
            SRC_SUB: begin
                if (roving) begin
                    o_d.valid = main_valid;
                    o_d.data  = main_data;
                    o_d.subst = 1'b1;
                end else begin
                    o_d.valid = sub_valid;
                    o_d.data  = sub_data;
                end
            end
            SRC_PAR:  begin o_d.valid = par_valid; o_d.data = par_data; end
            default:  begin o_d.valid = pat_valid; o_d.data = pat_data; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign data  = o_q.data;
    assign valid = o_q.valid;
    assign subst = o_q.subst;
endmodule

// File: rtl/rove_port_router.sv
module rove_port_router #(
    parameter int NPORT   = 6,
    parameter int W       = 8,
    parameter int DWELL_W = 8,
    localparam int PW     = $clog2(NPORT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [PW-1:0]      cfg_active,
    input  logic [PW-1:0]      cfg_sub,
    input  logic [DWELL_W-1:0] cfg_dwell,
    input  logic [1:0]         cfg_out0_src,
    input  logic [1:0]         cfg_out1_src,
    input  logic [NPORT*W-1:0] in_data,
    input  logic [NPORT-1:0]   in_valid,
    input  logic [W-1:0]       par_data,
    input  logic               par_valid,
    input  logic [W-1:0]       pat_data,
    input  logic               pat_valid,
    output logic [W-1:0]       main_data,
    output logic               main_valid,
    output logic [W-1:0]       sub_data,
    output logic               sub_valid,
    output logic [W-1:0]       out0_data,
    output logic               out0_valid,
    output logic [W-1:0]       out1_data,
    output logic               out1_valid,
    output logic [PW-1:0]      main_port,
    output logic [PW-1:0]      sub_port,
    output logic               rove_step,
    output logic               sel_err,
    output logic [1:0]         out_subst
);
    import rove_pkg::*;

    localparam int NOUT = 2;

    logic roving;
    assign roving = is_roving(cfg_mode);

    rove_scan #(.NPORT(NPORT), .DWELL_W(DWELL_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .roving(roving),
        .cfg_active(cfg_active), .cfg_sub(cfg_sub), .cfg_dwell(cfg_dwell),
        .main_port(main_port), .sub_port(sub_port),
        .step(rove_step), .err(sel_err)
    );

    rove_pipe_mux #(.NPORT(NPORT), .W(W)) u_main (
        .clk(clk), .rst_n(rst_n), .port(main_port),
        .lane_data(in_data), .lane_valid(in_valid),
        .data(main_data), .valid(main_valid)
    );

    rove_pipe_mux #(.NPORT(NPORT), .W(W)) u_sub (
        .clk(clk), .rst_n(rst_n), .port(sub_port),
        .lane_data(in_data), .lane_valid(in_valid),
        .data(sub_data), .valid(sub_valid)
    );

    logic [1:0]   src_a   [NOUT];
    logic [W-1:0] odata_a [NOUT];
    logic         ovalid_a[NOUT];

    assign src_a[0] = cfg_out0_src;
    assign src_a[1] = cfg_out1_src;

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        rove_out_mux #(.W(W)) u_out (
            .clk(clk), .rst_n(rst_n), .roving(roving), .src(src_a[g]),
            .main_data(main_data), .main_valid(main_valid),
            .sub_data(sub_data), .sub_valid(sub_valid),
            .par_data(par_data), .par_valid(par_valid),
            .pat_data(pat_data), .pat_valid(pat_valid),
            .data(odata_a[g]), .valid(ovalid_a[g]), .subst(out_subst[g])
        );
    end

    assign out0_data  = odata_a[0];
    assign out0_valid = ovalid_a[0];
    assign out1_data  = odata_a[1];
    assign out1_valid = ovalid_a[1];
endmodule

// File: rtl/rove_port_router_chk.sv
module rove_port_router_chk #(
    parameter int NPORT = 6,
    localparam int PW   = $clog2(NPORT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic [PW-1:0] cfg_active,
    input logic [1:0]    cfg_out0_src,
    input logic [1:0]    cfg_out1_src,
    input logic [PW-1:0] main_port,
    input logic [PW-1:0] sub_port,
    input logic          rove_step,
    input logic          sel_err,
    input logic [1:0]    out_subst
);
    logic rv;
    assign rv = (cfg_mode == 2'd0) || (cfg_mode == 2'd1);

    p_ports_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(main_port) < NPORT) && (int'(sub_port) < NPORT));

    p_no_step_matrix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rv) |-> !rove_step);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_err) |-> sel_err);

    p_illegal_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($past(cfg_active)) >= NPORT) |-> ($stable(main_port) && sel_err));

    p_sub_not_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rv) |-> (sub_port != main_port));

    p_subst0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rv) && ($past(cfg_out0_src) == 2'd1)) |-> out_subst[0]);

    p_subst1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rv) && ($past(cfg_out1_src) == 2'd1)) |-> out_subst[1]);

    p_subst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rv) |-> (out_subst == 2'b00));
endmodule

bind rove_port_router rove_port_router_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_active(cfg_active),
    .cfg_out0_src(cfg_out0_src), .cfg_out1_src(cfg_out1_src),
    .main_port(main_port), .sub_port(sub_port), .rove_step(rove_step),
    .sel_err(sel_err), .out_subst(out_subst)
);

// File: tb/tb_rove_port_router.sv
module tb_rove_port_router;
    localparam int NPORT = 6;
    localparam int W     = 8;
    localparam int DW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd2;
    logic [2:0] cfg_active = 3'd0, cfg_sub = 3'd1;
    logic [DW-1:0] cfg_dwell = 8'd4;
    logic [1:0] cfg_out0_src = 2'd0, cfg_out1_src = 2'd0;
    logic [NPORT*W-1:0] in_data;
    logic [NPORT-1:0] in_valid = '1;
    logic [W-1:0] par_data = 8'hAA, pat_data = 8'h55;
    logic par_valid = 1'b1, pat_valid = 1'b1;
    logic [W-1:0] main_data, sub_data, out0_data, out1_data;
    logic main_valid, sub_valid, out0_valid, out1_valid;
    logic [2:0] main_port, sub_port;
    logic rove_step, sel_err;
    logic [1:0] out_subst;

    always #4 clk = ~clk;   // 125 MHz

    rove_port_router #(.NPORT(NPORT), .W(W), .DWELL_W(DW)) dut (.*);

    typedef struct {
        int          due;
        int          sig;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    localparam int S_MAIN = 0, S_SUB = 1, S_MD = 2, S_SD = 3, S_O0 = 4,
                   S_O1 = 5, S_ERR = 6, S_SUBST = 7, S_STEP = 8;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] probe(int s);
        case (s)
            S_MAIN:  return 32'(main_port);
            S_SUB:   return 32'(sub_port);
            S_MD:    return {23'd0, main_valid, main_data};
            S_SD:    return {23'd0, sub_valid, sub_data};
            S_O0:    return {23'd0, out0_valid, out0_data};
            S_O1:    return {23'd0, out1_valid, out1_data};
            S_ERR:   return 32'(sel_err);
            S_SUBST: return 32'(out_subst);
            default: return 32'(rove_step);
        endcase
    endfunction

    task automatic expect_at(int k, int s, logic [31:0] v, string r);
        item_t it;
        it.due = cyc + k; it.sig = s; it.exp = v; it.req = r;
        sb.push_back(it);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_step();
        while (!rove_step) @(negedge clk);
    endtask

    // monitor: pops every item that falls due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [31:0] got;
                got = probe(sb[i].sig);
                n_tests++;
                if (got !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s sig%0d actual=%h expected=%h (cycle %0d)",
                             sb[i].req, sb[i].sig, got, sb[i].exp, cyc);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        for (int p = 0; p < NPORT; p++) in_data[p*W +: W] = 8'(8'h10 + p);
    end

    initial begin : driver
        tick(1);
        // R1 reset state
        expect_at(1, S_MAIN, 0, "R1");
        expect_at(1, S_SUB, 1, "R1");
        expect_at(1, S_MD, 0, "R1");
        expect_at(1, S_O1, 0, "R1");
        expect_at(1, S_ERR, 0, "R1");
        expect_at(1, S_STEP, 0, "R1");
        tick(3);
        rst_n = 1'b1;

        // R2 / R3 / R5 matrix routing, subpipe on output 1
        cfg_active = 3'd3; cfg_sub = 3'd5; cfg_out1_src = 2'd1;
        in_valid[5] = 1'b0;
        expect_at(1, S_MAIN, 3, "R2");
        expect_at(1, S_SUB, 5, "R2");
        expect_at(2, S_MD, {23'd0, 1'b1, 8'h13}, "R3");
        expect_at(2, S_SD, {23'd0, 1'b0, 8'h15}, "R3");
        expect_at(3, S_O0, {23'd0, 1'b1, 8'h13}, "R5");
        expect_at(3, S_O1, {23'd0, 1'b0, 8'h15}, "R5");
        expect_at(3, S_SUBST, 0, "R10");
        tick(4);
        in_valid[5] = 1'b1;

        // R4 illegal numbers hold and flag
        cfg_active = 3'd7; cfg_sub = 3'd6;
        expect_at(1, S_MAIN, 3, "R4");
        expect_at(1, S_SUB, 5, "R4");
        expect_at(1, S_ERR, 1, "R4");
        tick(2);

        // R5 parallel and pattern sources, independent per output
        cfg_active = 3'd2; cfg_sub = 3'd5;
        cfg_out0_src = 2'd2; cfg_out1_src = 2'd3;
        expect_at(1, S_O0, {23'd0, 1'b1, 8'hAA}, "R5");
        expect_at(1, S_O1, {23'd0, 1'b1, 8'h55}, "R5");
        expect_at(1, S_ERR, 1, "R4");
        tick(4);

        // R6 / R7 / R10 roving A, active 2, dwell 4
        cfg_out0_src = 2'd3; cfg_out1_src = 2'd1;
        cfg_mode = 2'd0;
        expect_at(2, S_O1, {23'd0, 1'b1, 8'h12}, "R10");
        expect_at(2, S_SUBST, 2'b10, "R10");
        expect_at(3, S_SUB, 5, "R6");
        expect_at(3, S_STEP, 0, "R6");
        expect_at(4, S_SUB, 0, "R7");
        expect_at(4, S_STEP, 1, "R6");
        expect_at(5, S_STEP, 0, "R6");
        expect_at(8, S_SUB, 1, "R6");
        expect_at(11, S_SUB, 1, "R6");
        expect_at(12, S_SUB, 3, "R7");
        tick(12);

        // R8 restart after active change
        wait_step();
        cfg_active = 3'd0;
        expect_at(1, S_MAIN, 0, "R8");
        expect_at(3, S_SUB, 3, "R8");
        expect_at(4, S_SUB, 1, "R8");
        expect_at(4, S_STEP, 1, "R8");
        tick(4);

        // R9 active collides with scanned port
        cfg_active = 3'd1;
        expect_at(1, S_MAIN, 1, "R9");
        expect_at(1, S_SUB, 2, "R9");
        expect_at(1, S_STEP, 1, "R9");
        expect_at(2, S_STEP, 0, "R9");
        expect_at(4, S_SUB, 2, "R9");
        expect_at(5, S_SUB, 3, "R9");
        tick(6);

        // R10 roving B also substitutes, on both outputs
        cfg_mode = 2'd1; cfg_out0_src = 2'd1;
        expect_at(2, S_SUBST, 2'b11, "R10");
        expect_at(2, S_O0, {23'd0, 1'b1, 8'h11}, "R10");
        expect_at(2, S_ERR, 1, "R4");
        tick(4);

        // R2 mode 3 behaves as matrix
        cfg_mode = 2'd3; cfg_sub = 3'd4;
        expect_at(1, S_SUB, 4, "R2");
        expect_at(2, S_SUBST, 0, "R2");
        expect_at(3, S_O1, {23'd0, 1'b1, 8'h14}, "R2");
        expect_at(2, S_STEP, 0, "R2");
        expect_at(6, S_STEP, 0, "R2");
        expect_at(6, S_SUB, 4, "R2");
        tick(10);
        while (sb.size() != 0) tick(1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule